// File: doc/BRIEF.md
# Calibration Ready Sequencer

This block drives the ready flag of a converter that calibrates itself after an explicit request. The request input, `calReqN`, is active low and is sampled on the block clock. Holding it low parks the block with ready high. Releasing it high after at least one low sample starts a sequence. The block first waits a short fixed lag. It then pulls `ready` low for a programmable number of clocks, which stands in for the analog calibration. After that, `ready` returns high and the block waits for the next low-then-high pulse.

Pulling `calReqN` low at any point of a sequence abandons it. The next release starts a full-length sequence from the beginning. The block does not start on its own at power-up: nothing happens until the first low-to-high pulse arrives. `calActive` is high for the whole of a running sequence, lag included, so downstream logic can hold off while calibration is under way.

Top module: `cal_ready_seq`

## Requirements
- R1: While `calReqN` is sampled low, `ready` is high and `calActive` is low after every such clock edge, however long the low hold lasts.
- R2: A sequence starts only at a clock edge that samples `calReqN` high when the previous edge sampled it low. A steady high level never starts a sequence.
- R3: Let edge k be the first edge that samples `calReqN` high after a low. `ready` stays high after edges k and k+1 and is low after edge k+2 (`LAG_CYCLES` = 2).
- R4: `ready` stays low for exactly `CAL_CYCLES` clocks and is high again after edge k+2+`CAL_CYCLES`.
- R5: Once a sequence completes, `ready` stays high and `calActive` low while `calReqN` stays high, until a new low-then-high pulse arrives.
- R6: If `calReqN` is sampled low during the lag or the busy period, `ready` is high and `calActive` is low after that edge. The next release then gives a full `CAL_CYCLES` busy period.
- R7: `calActive` is high after edges k through k+1+`CAL_CYCLES` and low after edge k+2+`CAL_CYCLES`, covering both the lag and the busy period.
- R8: `ready` is always driven to a known 0 or 1 once the first low sample of `calReqN` has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all state changes on its rising edge |
| calReqN | input | 1 | Active-low calibration request; a release from low starts a sequence |
| ready | output | 1 | High when idle, low during the busy period |
| calActive | output | 1 | High from sequence start through the end of the busy period |

## Verification
The assertions assume that `calReqN` is a clean synchronous level. They also assume that it is held low for at least one clock before the first release, since the block has no other way to reach a known state. Most of the properties switch off while `calReqN` is low, because a low level is the block's reset. The stimulus always opens with a low hold, changes `calReqN` only between clock edges, and puts at least one low sample between releases. It covers single-cycle lows, aborts in the lag and in the busy period, and a long low hold.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LAG  = 2'd1,
    ST_BUSY = 2'd2
  } seq_state_e;

  // strobes from control to datapath, one clock's worth of commands
  typedef struct packed {
    logic loadLag;
    logic loadCal;
    logic countDown;
    logic clearCnt;
    logic readyLow;
    logic readyHigh;
  } seq_strobe_t;

endpackage

// File: rtl/cal_seq_dpath.sv
module cal_seq_dpath
  import cal_seq_pkg::*;
#(
  parameter int CAL_CYCLES = 750000,
  parameter int LAG_CYCLES = 2,
  parameter int CNT_W      = 20
) (
  input  logic        clk,
  input  logic        pinRaw,
  input  seq_strobe_t strobe,
  output logic        pinRise,
  output logic        cntZero,
  output logic        ready
);

  localparam logic [CNT_W-1:0] CAL_LOAD = CNT_W'(CAL_CYCLES - 1);
  localparam logic [CNT_W-1:0] LAG_LOAD = CNT_W'(LAG_CYCLES - 1);
  localparam logic [CNT_W-1:0] CNT_TOP  = (CAL_LOAD > LAG_LOAD) ? CAL_LOAD : LAG_LOAD;

  logic             pinQ;
  logic [CNT_W-1:0] cnt;
  logic             readyQ;

  // single sampling stage used for edge detection
  always_ff @(posedge clk) pinQ <= pinRaw;
  assign pinRise = pinRaw & ~pinQ;

  always_ff @(posedge clk) begin
    if (strobe.loadLag)        cnt <= LAG_LOAD;
    else if (strobe.loadCal)   cnt <= CAL_LOAD;
    else if (strobe.countDown) cnt <= cnt - 1'b1;
    else if (strobe.clearCnt)  cnt <= '0;
  end
  assign cntZero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (strobe.readyLow)       readyQ <= 1'b0;
    else if (strobe.readyHigh) readyQ <= 1'b1;
  end
  assign ready = readyQ;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!pinRaw)
    cnt <= CNT_TOP);  // R4

  AST_READY_KNOWN: assert property (@(posedge clk) disable iff (!pinRaw)
    !$isunknown(readyQ));  // R8

  AST_NO_DOWN_AT_ZERO: assert property (@(posedge clk) disable iff (!pinRaw)
    cntZero |-> !strobe.countDown);  // R4

endmodule

// File: rtl/cal_seq_ctrl.sv
module cal_seq_ctrl
  import cal_seq_pkg::*;
(
  input  logic        clk,
  input  logic        pinRaw,
  input  logic        pinRise,
  input  logic        cntZero,
  output seq_strobe_t strobe,
  output logic        calActive
);

  seq_state_e state;
  seq_state_e stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    if (!pinRaw) begin
      // a low level is the block's only reset: abort and park
      stateNext        = ST_IDLE;
      strobe.clearCnt  = 1'b1;
      strobe.readyHigh = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (pinRise) begin
            stateNext      = ST_LAG;
            strobe.loadLag = 1'b1;
          end
        end
        ST_LAG: begin
          if (cntZero) begin
            stateNext       = ST_BUSY;
            strobe.loadCal  = 1'b1;
            strobe.readyLow = 1'b1;
          end else begin
            strobe.countDown = 1'b1;
          end
        end
        ST_BUSY: begin
          if (cntZero) begin
            stateNext        = ST_IDLE;
            strobe.readyHigh = 1'b1;
          end else begin
            strobe.countDown = 1'b1;
          end
        end
        default: begin
          stateNext        = ST_IDLE;
          strobe.readyHigh = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) state <= stateNext;

  assign calActive = (state != ST_IDLE);

  AST_IDLE_NO_SELF_START: assert property (@(posedge clk) disable iff (!pinRaw)
    (state == ST_IDLE && !pinRise) |=> (state == ST_IDLE));  // R2

  AST_RISE_STARTS_LAG: assert property (@(posedge clk) disable iff (!pinRaw)
    (state == ST_IDLE && pinRise) |=> (state == ST_LAG));  // R2

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!pinRaw)
    state != seq_state_e'(2'd3));  // R7

  AST_SINGLE_LOAD: assert property (@(posedge clk) disable iff (!pinRaw)
    $countones({strobe.loadLag, strobe.loadCal, strobe.countDown}) <= 1);  // R4

endmodule

// File: rtl/cal_ready_seq.sv
module cal_ready_seq
  import cal_seq_pkg::*;
#(
  parameter int CAL_CYCLES = 750000,
  parameter int LAG_CYCLES = 2
) (
  input  logic clk,
  input  logic calReqN,
  output logic ready,
  output logic calActive
);

  localparam int CNT_MAX = (CAL_CYCLES > LAG_CYCLES) ? CAL_CYCLES : LAG_CYCLES;
  localparam int CNT_W   = (CNT_MAX < 2) ? 1 : $clog2(CNT_MAX);

  seq_strobe_t strobe;
  logic        pinRise;
  logic        cntZero;

  cal_seq_ctrl u_ctrl (
    .clk       (clk),
    .pinRaw    (calReqN),
    .pinRise   (pinRise),
    .cntZero   (cntZero),
    .strobe    (strobe),
    .calActive (calActive)
  );

  cal_seq_dpath #(
    .CAL_CYCLES (CAL_CYCLES),
    .LAG_CYCLES (LAG_CYCLES),
    .CNT_W      (CNT_W)
  ) u_dpath (
    .clk     (clk),
    .pinRaw  (calReqN),
    .strobe  (strobe),
    .pinRise (pinRise),
    .cntZero (cntZero),
    .ready   (ready)
  );

  // the request pin is the block's reset, so this property has nothing to disable on
  AST_LOW_PARKS: assert property (@(posedge clk)
    !calReqN |=> (ready && !calActive));  // R1

  AST_READY_LAG: assert property (@(posedge clk) disable iff (!calReqN)
    $rose(calActive) |=> ready ##1 !ready);  // R3

  AST_READY_LOW_IN_SEQ: assert property (@(posedge clk) disable iff (!calReqN)
    !ready |-> calActive);  // R7

  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!calReqN)
    $fell(calActive) |-> ready);  // R4

endmodule

// File: tb/cal_ready_seq_test.sv
module cal_ready_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int CAL        = 20;
  localparam int LAG        = 2;

  logic clk = 1'b0;
  logic calReqN = 1'b0;
  logic ready;
  logic calActive;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic  expReady;
    logic  expActive;
    string tag;
  } exp_t;

  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cal_ready_seq #(.CAL_CYCLES(CAL), .LAG_CYCLES(LAG)) uut (
    .clk       (clk),
    .calReqN   (calReqN),
    .ready     (ready),
    .calActive (calActive)
  );

  // driver: hold the request low, expectations for each following edge
  task automatic lowFor(input int n, input string firstTag);
    for (int i = 1; i <= n; i++) begin
      exp_t e;
      @(negedge clk);
      calReqN = 1'b0;
      e.expReady  = 1'b1;
      e.expActive = 1'b0;
      e.tag       = (i == 1) ? firstTag : "R1";
      q.push_back(e);
    end
  endtask

  // driver: release high; edge i counts from the first high sample
  task automatic highFor(input int n);
    for (int i = 1; i <= n; i++) begin
      exp_t e;
      @(negedge clk);
      calReqN = 1'b1;
      if (i <= LAG) begin
        e.expReady = 1'b1; e.expActive = 1'b1; e.tag = "R2 R3 R7";
      end else if (i <= LAG + CAL) begin
        e.expReady = 1'b0; e.expActive = 1'b1; e.tag = "R4 R7";
      end else begin
        e.expReady = 1'b1; e.expActive = 1'b0; e.tag = "R4 R5";
      end
      q.push_back(e);
    end
  endtask

  // monitor: compare one item per clock, away from the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (ready !== e.expReady || calActive !== e.expActive) begin
          errors++;
          $display("FAIL %s ready=%b exp=%b calActive=%b exp=%b t=%0t",
                   e.tag, ready, e.expReady, calActive, e.expActive, $time);
        end
        checks++;
        if ($isunknown(ready)) begin  // R8
          errors++;
          $display("FAIL R8 ready=%b exp=known", ready);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    lowFor(5, "R1");                 // reset state, no self start
    highFor(LAG + CAL + 8);          // full sequence, then stays idle (R5)
    lowFor(1, "R1");                 // minimal low pulse re-arms
    highFor(LAG + CAL + 3);
    lowFor(60, "R1");                // long low hold
    highFor(1);                      // abort in the lag (R6)
    lowFor(3, "R6 R1");
    highFor(LAG + 7);                // abort mid-busy (R6)
    lowFor(2, "R6 R1");
    highFor(LAG + CAL + 4);          // full length after abort (R6)
    lowFor(1, "R1");
    @(posedge clk);
    #2;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule